// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is a host-side controller for an 8-channel, 10-bit serial analog-to-digital converter. The link has four wires: an active-low select, a serial clock that the host drives, a command line to the converter and a result line from it. A strobe input from the converter completes the set. The converter runs from the host's serial clock. Each conversion frame starts by shifting an 8-bit command byte into the converter. The controller then watches for the converter's one-clock strobe and captures the 10 result bits that follow, most significant bit first. The result appears on a parallel output together with a one-cycle valid pulse. If no strobe arrives within the 15-clock frame, the frame ends with a one-cycle timeout pulse instead.

The serial clock comes from the system clock through a programmable half-period divider. Between frames the select line stays high for a minimum gap so that the converter has time to acquire the signal. That gap is the larger of a programmable cycle count and a hard floor. The floor is 1.5 µs at the system clock frequency, which is given as a parameter. A single conversion runs on a start pulse. A continuous input repeats frames back to back, and each frame still respects the gap. The command byte is held in a register whose reset value is 0xFF: single-ended, unipolar, channel 7, externally clocked, never powered down.

The sequencer moves through six named states. `ST_GAP` holds select high until the gap has elapsed and is the state after reset. `ST_IDLE` waits for work. `ST_SEND` shifts out the command byte. `ST_HUNT` looks for the strobe. `ST_READ` captures the result bits. `ST_CLOSE` returns the serial clock low. The transitions are these:
- `ST_GAP` goes to `ST_IDLE` once the gap is met.
- `ST_IDLE` goes to `ST_SEND` on a start, a pending start or the continuous input.
- `ST_SEND` goes to `ST_HUNT` on the 8th rising edge.
- `ST_HUNT` goes to `ST_READ` when the strobe is sampled high, and to `ST_CLOSE` on a miss at the 15th rising edge.
- `ST_READ` goes to `ST_CLOSE` after the 10th result edge.
- `ST_CLOSE` goes to `ST_GAP` on the next falling edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `sel_n_o` is 1 and `ser_clk_o`, `cmd_o`, `busy_o`, `valid_o` and `timeout_o` are 0. No frame begins unless `start_i` or `cont_i` asks for one.
- R2: The command byte register resets to 0xFF and is loaded from `cmd_byte_i` when `cmd_we_i` is high. Every frame latches the register at frame start and sends all 8 bits on `cmd_o`, most significant bit first, on the first 8 rising edges of `ser_clk_o`. `cmd_o` changes only while `ser_clk_o` is low.
- R3: `ser_clk_o` is low whenever `sel_n_o` is high. Within a frame, each high phase of `ser_clk_o` lasts `div_i`+1 system cycles, with `div_i` latched at frame start.
- R4: `strobe_i` and `res_bit_i` are sampled in the system cycle in which `ser_clk_o` rises. The strobe is searched for only on rising edges 9 through 15 of the frame. A strobe that is high on an earlier edge is ignored.
- R5: If the strobe is sampled high on rising edge k, the next 10 rising edges capture the result MSB first. The frame has k+10 rising edges in total. `valid_o` is high for the single cycle after the 10th capture edge, and `result_o` holds the captured word from then until the next frame starts.
- R6: If the strobe is not seen by rising edge 15, the frame has exactly 15 rising edges, `timeout_o` pulses for one cycle and `valid_o` stays low.
- R7: After the last rising edge of a frame, `ser_clk_o` falls on the next divider tick, and `sel_n_o` rises at that same clock edge.
- R8: Between frames, and from reset to the first frame, `sel_n_o` stays high for at least max(`gap_i`, FLOOR) system cycles. FLOOR is ceil(1.5 × SYS_CLK_KHZ / 1000).
- R9: A `start_i` pulse in `ST_IDLE` starts a frame at once. A `start_i` pulse in any other state is remembered, one deep, and serves the next frame.
- R10: While `cont_i` is high, frames follow one another without `start_i`, each separated by the gap of R8.
- R11: `busy_o` rises at the clock edge at which `sel_n_o` falls, and falls at the edge at which `valid_o` or `timeout_o` rises. `sel_n_o` is low whenever `busy_o` is high.
- R12: `valid_o` and `timeout_o` are never high together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion |
| cont_i | input | 1 | Repeat conversions while high |
| cmd_we_i | input | 1 | Load the command byte register |
| cmd_byte_i | input | CMD_W | New command byte |
| div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| gap_i | input | GAP_W | Programmed minimum select-high gap, in system cycles |
| strobe_i | input | 1 | Converter strobe, one serial clock before the result MSB |
| res_bit_i | input | 1 | Serial result from the converter |
| sel_n_o | output | 1 | Active-low converter select |
| ser_clk_o | output | 1 | Serial clock |
| cmd_o | output | 1 | Serial command to the converter |
| result_o | output | RES_W | Last captured conversion result |
| valid_o | output | 1 | One-cycle result pulse |
| timeout_o | output | 1 | One-cycle missing-strobe pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
The bound checker looks at the link's framing on every cycle. It checks that the serial clock stays parked low while select is high and that the command line moves only during the clock's low phase. It checks that a busy frame holds select low and that busy ends only on a valid or timeout pulse. It also checks that these two pulses are single-cycle and mutually exclusive, that no select-high interval is shorter than the hard floor, and that no frame exceeds the largest legal edge count. The bench's converter model is needed to show the rest:
- the command byte that is actually received;
- the placement of the hunt window, including a strobe that arrives too early;
- the captured result word and the edge count for each strobe position;
- the programmed half period;
- the queued start and continuous repetition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_HUNT,
        ST_READ,
        ST_CLOSE,
        ST_GAP
    } seq_state_t;

    // Smallest select-high time, in system cycles, that covers 1.5 us.
    function automatic int floor_cycles(input int sys_khz);
        return (sys_khz * 3 + 1999) / 2000;
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick   = en_i && (cnt_q == half_i);
    assign rise_o = tick && !sclk_o;
    assign fall_o = tick && sclk_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_tx_shift.sv
module adc_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         bit_o
);

    logic [W-1:0] sh_q;

    assign bit_o = sh_q[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= data_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (clr_i) begin
            word_o <= '0;
        end else if (shift_i) begin
            word_o <= {word_o[W-2:0], bit_i};
        end
    end

endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
    parameter int GAP_W     = 8,
    parameter int FLOOR_CYC = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             done_o
);

    localparam int FW = $clog2(FLOOR_CYC + 1);
    localparam int CW = ((GAP_W > FW) ? GAP_W : FW) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need;

    always_comb begin
        if (CW'(gap_i) > CW'(FLOOR_CYC)) begin
            need = CW'(gap_i);
        end else begin
            need = CW'(FLOOR_CYC);
        end
    end

    assign done_o = (cnt_q >= need);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int RES_W       = 10,
    parameter int FRAME_CLKS  = 15,
    parameter int DIV_W       = 4,
    parameter int GAP_W       = 8,
    parameter int SYS_CLK_KHZ = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_byte_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             strobe_i,
    input  logic             res_bit_i,
    output logic             sel_n_o,
    output logic             ser_clk_o,
    output logic             cmd_o,
    output logic [RES_W-1:0] result_o,
    output logic             valid_o,
    output logic             timeout_o,
    output logic             busy_o
);

    localparam int FLOOR_CYC = floor_cycles(SYS_CLK_KHZ);
    localparam int EC_W      = $clog2(FRAME_CLKS + 1);
    localparam int BC_W      = $clog2(RES_W + 1);

    seq_state_t       st_q, st_d;
    logic [EC_W-1:0]  edge_q;
    logic [BC_W-1:0]  bit_q;
    logic [CMD_W-1:0] cmd_q;
    logic [DIV_W-1:0] div_q;
    logic             pend_q;

    logic clk_en, rise, fall, gap_done;
    logic go, launch, last_cmd, hit, miss, last_bit, closed;

    // Event decode
    assign clk_en   = (st_q == ST_SEND) || (st_q == ST_HUNT) ||
                      (st_q == ST_READ) || (st_q == ST_CLOSE);
    assign go       = start_i || cont_i || pend_q;
    assign launch   = (st_q == ST_IDLE) && go;
    assign last_cmd = rise && (st_q == ST_SEND) && (edge_q == EC_W'(CMD_W - 1));
    assign hit      = rise && (st_q == ST_HUNT) && strobe_i;
    assign miss     = rise && (st_q == ST_HUNT) && !strobe_i &&
                      (edge_q == EC_W'(FRAME_CLKS - 1));
    assign last_bit = rise && (st_q == ST_READ) && (bit_q == BC_W'(RES_W - 1));
    assign closed   = fall && (st_q == ST_CLOSE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_GAP;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (launch)   st_d = ST_SEND;
            ST_SEND:  if (last_cmd) st_d = ST_HUNT;
            ST_HUNT: begin
                if (hit) begin
                    st_d = ST_READ;
                end else if (miss) begin
                    st_d = ST_CLOSE;
                end
            end
            ST_READ:  if (last_bit) st_d = ST_CLOSE;
            ST_CLOSE: if (closed)   st_d = ST_GAP;
            ST_GAP:   if (gap_done) st_d = ST_IDLE;
            default:  st_d = ST_GAP;
        endcase
    end

    // Registered outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_n_o   <= 1'b1;
            busy_o    <= 1'b0;
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
            pend_q    <= 1'b0;
            edge_q    <= '0;
            bit_q     <= '0;
            cmd_q     <= '1;
            div_q     <= '0;
        end else begin
            valid_o   <= last_bit;
            timeout_o <= miss;
            if (cmd_we_i) begin
                cmd_q <= cmd_byte_i;
            end
            if (launch) begin
                sel_n_o <= 1'b0;
                busy_o  <= 1'b1;
                pend_q  <= 1'b0;
                edge_q  <= '0;
                bit_q   <= '0;
                div_q   <= div_i;
            end else begin
                if (start_i) begin
                    pend_q <= 1'b1;
                end
                if (rise && ((st_q == ST_SEND) || (st_q == ST_HUNT))) begin
                    edge_q <= edge_q + 1'b1;
                end
                if (rise && (st_q == ST_READ)) begin
                    bit_q <= bit_q + 1'b1;
                end
                if (last_bit || miss) begin
                    busy_o <= 1'b0;
                end
                if (closed) begin
                    sel_n_o <= 1'b1;
                end
            end
        end
    end

    adc_sclk_gen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .half_i (div_q),
        .sclk_o (ser_clk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    adc_tx_shift #(
        .W (CMD_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .data_i  (cmd_q),
        .shift_i (fall && clk_en),
        .bit_o   (cmd_o)
    );

    adc_rx_shift #(
        .W (RES_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (launch),
        .shift_i (rise && (st_q == ST_READ)),
        .bit_i   (res_bit_i),
        .word_o  (result_o)
    );

    adc_gap_timer #(
        .GAP_W     (GAP_W),
        .FLOOR_CYC (FLOOR_CYC)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (closed),
        .run_i  (st_q == ST_GAP),
        .gap_i  (gap_i),
        .done_o (gap_done)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int FRAME_CLKS  = 15,
    parameter int SYS_CLK_KHZ = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic sel_n_o,
    input logic ser_clk_o,
    input logic cmd_o,
    input logic busy_o,
    input logic valid_o,
    input logic timeout_o
);

    localparam int FLOOR_CYC = floor_cycles(SYS_CLK_KHZ);
    localparam int MAX_RISES = FRAME_CLKS + RES_W;

    int   hi_cnt;
    int   rises;
    logic clk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            rises  <= 0;
            clk_d  <= 1'b0;
        end else begin
            clk_d  <= ser_clk_o;
            hi_cnt <= sel_n_o ? hi_cnt + 1 : 0;
            if (sel_n_o) begin
                rises <= 0;
            end else if (ser_clk_o && !clk_d) begin
                rises <= rises + 1;
            end
        end
    end

    a_r3_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_o |-> !ser_clk_o);

    a_r2_cmd_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> !ser_clk_o);

    a_r7_select_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n_o) |-> !ser_clk_o);

    a_r8_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n_o) |-> (hi_cnt >= FLOOR_CYC));

    a_r11_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sel_n_o);

    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (valid_o || timeout_o));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && timeout_o));

    a_r12_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r12_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r5_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        rises <= MAX_RISES);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .RES_W       (RES_W),
    .FRAME_CLKS  (FRAME_CLKS),
    .SYS_CLK_KHZ (SYS_CLK_KHZ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_o   (sel_n_o),
    .ser_clk_o (ser_clk_o),
    .cmd_o     (cmd_o),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .timeout_o (timeout_o)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ        = 20000;
    localparam int FLOOR      = 30;     // ceil(1.5 us * 20 MHz)
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, cont_i = 1'b0, cmd_we_i = 1'b0;
    logic [7:0] cmd_byte_i = 8'h00;
    logic [3:0] div_i = 4'd0;
    logic [7:0] gap_i = 8'd0;
    logic       strobe_i, res_bit_i;
    logic       sel_n_o, ser_clk_o, cmd_o, valid_o, timeout_o, busy_o;
    logic [9:0] result_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(
        .SYS_CLK_KHZ (KHZ)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .cont_i (cont_i),
        .cmd_we_i (cmd_we_i), .cmd_byte_i (cmd_byte_i), .div_i (div_i),
        .gap_i (gap_i), .strobe_i (strobe_i), .res_bit_i (res_bit_i),
        .sel_n_o (sel_n_o), .ser_clk_o (ser_clk_o), .cmd_o (cmd_o),
        .result_o (result_o), .valid_o (valid_o), .timeout_o (timeout_o),
        .busy_o (busy_o)
    );

    // Converter model: acts on falling serial clock edges, records the command byte.
    int         m_rises, m_pos, m_left, gap_run, last_gap, hi_run, half_bad, exp_half;
    logic [7:0] m_byte;
    logic [9:0] m_data, m_sh;
    logic       m_strb, m_bit, prev_clk, prev_sel;

    assign strobe_i  = m_strb;
    assign res_bit_i = m_bit;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_rises = 0; m_left = 0; gap_run = 0; last_gap = 0; hi_run = 0;
            half_bad = 0; m_byte = 8'h00; m_sh = '0; m_strb = 1'b0; m_bit = 1'b0;
            prev_clk = 1'b0; prev_sel = 1'b1;
        end else begin
            if (sel_n_o) begin
                gap_run++;
                m_strb = 1'b0; m_bit = 1'b0; m_left = 0;
            end else begin
                if (prev_sel) begin
                    last_gap = gap_run; gap_run = 0; m_rises = 0;
                    m_byte = 8'h00; half_bad = 0; hi_run = 0;
                end
                if (ser_clk_o && !prev_clk) begin
                    m_rises++;
                    if (m_rises <= 8) m_byte = {m_byte[6:0], cmd_o};
                    hi_run = 0;
                end
                if (ser_clk_o) hi_run++;
                if (!ser_clk_o && prev_clk) begin
                    if (hi_run != exp_half) half_bad++;
                    if (m_strb) begin
                        m_strb = 1'b0; m_sh = m_data; m_left = 10;
                    end
                    if (m_left > 0) begin
                        m_bit = m_sh[9]; m_sh = {m_sh[8:0], 1'b0}; m_left--;
                    end else begin
                        m_bit = 1'b0;
                    end
                    if (m_pos != 0 && m_rises == m_pos - 1) m_strb = 1'b1;
                end
            end
            prev_clk = ser_clk_o;
            prev_sel = sel_n_o;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input string what, input int act, input int lim);
        checks++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    function automatic int eff_gap(input int g);
        return (g > FLOOR) ? g : FLOOR;
    endfunction

    function automatic bit expect_timeout(input int pos);
        return (pos < 9) || (pos > 15);
    endfunction

    function automatic int expect_rises(input int pos);
        return expect_timeout(pos) ? 15 : pos + 10;
    endfunction

    logic [7:0] exp_byte = 8'hFF;

    task automatic wait_for(input string req, input int which, input int limit);
        int n = 0;
        while (n < limit) begin
            if (which == 0 && !sel_n_o) return;
            if (which == 1 && sel_n_o) return;
            if (which == 2 && (valid_o || timeout_o)) return;
            tick();
            n++;
        end
        check(req, "wait expired", n, -1);
    endtask

    task automatic run_frame(input int div, input int gap, input bit wr,
                             input logic [7:0] bval, input logic [9:0] data, input int pos);
        div_i = 4'(div); gap_i = 8'(gap); exp_half = div + 1;
        m_data = data; m_pos = pos;
        if (wr) begin
            cmd_byte_i = bval; cmd_we_i = 1'b1; tick(); cmd_we_i = 1'b0;
            exp_byte = bval;
        end
        start_i = 1'b1; tick(); start_i = 1'b0;
        wait_for("R9", 0, 2000);
        check("R11", "busy at frame start", int'(busy_o), 1);
        check_ge("R8", "select-high gap", last_gap, eff_gap(gap));
        wait_for("R5", 2, 5000);
        if (expect_timeout(pos)) begin
            check("R6", "timeout pulse", int'(timeout_o), 1);
            check("R6", "no valid on miss", int'(valid_o), 0);
        end else begin
            check("R5", "valid pulse", int'(valid_o), 1);
            check("R4 R5", "result word", int'(result_o), int'(data));
        end
        check("R11", "busy cleared", int'(busy_o), 0);
        tick();
        check("R12", "valid width", int'(valid_o), 0);
        check("R12", "timeout width", int'(timeout_o), 0);
        if (!expect_timeout(pos))
            check("R5", "result held", int'(result_o), int'(data));
        wait_for("R7", 1, 200);
        check("R7", "clock low at close", int'(ser_clk_o), 0);
        check("R5 R6", "rising edges", m_rises, expect_rises(pos));
        check("R2", "command byte", int'(m_byte), int'(exp_byte));
        check("R3", "bad half periods", half_bad, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int lows;
        void'($urandom(32'd4242));
        m_pos = 0; m_data = '0; exp_half = 1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", "select idle", int'(sel_n_o), 1);
        check("R1", "clock idle", int'(ser_clk_o), 0);
        check("R1", "command idle", int'(cmd_o), 0);
        check("R1", "busy idle", int'(busy_o), 0);
        check("R1", "valid idle", int'(valid_o), 0);
        check("R1", "timeout idle", int'(timeout_o), 0);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            tick();
            if (!sel_n_o) lows++;
        end
        check("R1", "no unrequested frame", lows, 0);

        // Default byte, earliest strobe, fastest clock, gap at floor
        run_frame(0, 0, 1'b0, 8'h00, 10'h2A5, 9);
        // Latest strobe, programmed gap above floor
        run_frame(2, 50, 1'b1, 8'h8E, 10'h001, 15);
        // No strobe at all
        run_frame(1, 10, 1'b0, 8'h00, 10'h155, 0);
        // Strobe during command byte is ignored (R4)
        run_frame(1, 0, 1'b1, 8'h3C, 10'h3FF, 5);
        run_frame(3, 35, 1'b0, 8'h00, 10'h200, 12);

        // Continuous mode
        div_i = 4'd1; gap_i = 8'd40; exp_half = 2; m_data = 10'h0F3; m_pos = 11;
        cont_i = 1'b1;
        for (int f = 0; f < 2; f++) begin
            wait_for("R10", 2, 5000);
            check("R10", "continuous valid", int'(valid_o), 1);
            check("R10", "continuous result", int'(result_o), 10'h0F3);
            tick();
        end
        check_ge("R10", "gap between repeats", last_gap, 40);
        cont_i = 1'b0;
        wait_for("R10", 1, 200);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (!sel_n_o) lows++;
        end
        check("R10", "stops after continuous drops", lows, 0);

        // Random frames
        for (int k = 0; k < 14; k++) begin
            int r, pos;
            r = int'($urandom % 10);
            pos = (r == 0) ? 0 : ((r == 1) ? 3 + int'($urandom % 5) : 9 + int'($urandom % 7));
            run_frame(int'($urandom % 4), int'($urandom % 70), 1'($urandom % 2),
                      8'($urandom), 10'($urandom), pos);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule